// File: doc/BRIEF.md
# Dual FIFO Trigger Interrupt Controller

This block holds the two character buffers of a serial port: a transmit FIFO that software fills and the shifter drains, and a receive FIFO that the shifter fills and software drains. Each buffer is 16 bytes deep by default. Each has its own level output and its own programmable trigger level. From the two levels the block derives three interrupt flags: receive data ready, transmit space available, and receive time-out.

A control write sets four fields at once: a FIFO enable, a receive trigger selector, a transmit trigger selector and an enhanced-mode enable. A transmit selector is always stored. It only steers the transmit interrupt while enhanced mode is set. Otherwise the transmit trigger is fixed at one character, which is also the state after reset. The receive time-out catches bytes that sit below the trigger. Its length is a parameter, counted in character times of a parameterised cycle length.

Top module: `fifo_trig_irq`

## Requirements
- R1: After reset, both levels read 0. All three interrupt flags and both overrun flags read 0. Enhanced mode and the FIFO enable are cleared.
- R2: Each FIFO returns bytes in push order and holds up to DEPTH (16) bytes. The output byte is updated at the clock edge that accepts a pop, and the level output changes at the same edge.
- R3: A push into a full FIFO drops the byte, leaves the contents unchanged and sets that FIFO's overrun flag. The flag stays set until the FIFOs are disabled. A push and a pop in the same cycle on a full FIFO are both accepted, and the overrun flag is not set.
- R4: A pop from an empty FIFO leaves the output byte at its last value and leaves the level at 0.
- R5: Writing the FIFO enable as 0 empties both FIFOs and clears both overrun flags. While the FIFOs are disabled, pushes are ignored and all interrupt flags read 0.
- R6: The receive selector codes 0, 1, 2 and 3 give triggers of 1, DEPTH/4, DEPTH/2 and DEPTH-2 characters (1, 4, 8, 14 at the default). The receive data interrupt is 1 exactly while the receive level is at or above the trigger, and it is updated at the same edge as the level.
- R7: The transmit interrupt is 1 exactly while the transmit level is below the effective transmit trigger. The effective trigger is the transmit selector (same encoding as R6) while enhanced mode is 1, and 1 otherwise.
- R8: The receive time-out flag rises exactly TOUT_CHARS*CHAR_CYCLES clock edges after the last receive push, receive pop or control write, provided the receive level stayed between 1 and trigger-1 throughout. The next such event clears it.
- R9: The time-out flag never rises while the receive level is at or above the receive trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load all four control fields this cycle |
| cfg_fifo_en | input | 1 | FIFO enable field |
| cfg_rx_sel | input | 2 | Receive trigger selector |
| cfg_tx_sel | input | 2 | Transmit trigger selector |
| cfg_enh | input | 1 | Enhanced-mode enable (activates transmit selector) |
| tx_push | input | 1 | Write a byte into the transmit FIFO |
| tx_din | input | DW | Transmit byte in |
| tx_pop | input | 1 | Take a byte from the transmit FIFO |
| tx_dout | output | DW | Last byte taken from the transmit FIFO |
| tx_level | output | CW | Transmit FIFO fill level |
| tx_ovr | output | 1 | Transmit overrun flag |
| rx_push | input | 1 | Write a byte into the receive FIFO |
| rx_din | input | DW | Receive byte in |
| rx_pop | input | 1 | Take a byte from the receive FIFO |
| rx_dout | output | DW | Last byte taken from the receive FIFO |
| rx_level | output | CW | Receive FIFO fill level |
| rx_ovr | output | 1 | Receive overrun flag |
| irq_rx_data | output | 1 | Receive level at or above trigger |
| irq_tx_empty | output | 1 | Transmit level below effective trigger |
| irq_rx_tout | output | 1 | Receive time-out |

## Verification
The push and the pop of one FIFO can land in the same cycle when that FIFO is full. This is the case where the overrun logic and the read path could disagree. The bench fills the receive FIFO to 16 and then raises push and pop together. It expects the level to stay at 16, the overrun flag to stay 0 and the oldest byte to appear at the output. The full drain that follows must show the new byte queued last and a later lone push dropped. A second collision, between a receive push and a running time-out count, is provoked by pushing just before the count would expire. The bench judges it by the flag staying low until a full window after the later push.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  // Trigger selector codes, shared by receive and transmit.
  typedef enum logic [1:0] {
    TRIG_ONE  = 2'd0,
    TRIG_QTR  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_NEAR = 2'd3
  } trig_sel_t;

  typedef struct packed {
    logic      en;
    trig_sel_t rx_sel;
    trig_sel_t tx_sel;
    logic      enh;
  } trig_cfg_t;

endpackage

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter int  DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  trig_cfg_t     cfg_in,
  output logic          en_q,
  output logic          en_nxt,
  output logic [CW-1:0] rx_trig_q,
  output logic [CW-1:0] rx_trig_nxt,
  output logic [CW-1:0] tx_trig_nxt
);

  trig_cfg_t cfg_q;
  trig_cfg_t cfg_n;

  function automatic logic [CW-1:0] sel_to_level(input trig_sel_t s);
    case (s)
      TRIG_ONE:  return CW'(1);
      TRIG_QTR:  return CW'(DEPTH / 4);
      TRIG_HALF: return CW'(DEPTH / 2);
      default:   return CW'(DEPTH - 2);
    endcase
  endfunction

  always_comb begin
    cfg_n = cfg_we ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_n;
  end

  assign en_q        = cfg_q.en;
  assign en_nxt      = cfg_n.en;
  assign rx_trig_q   = sel_to_level(cfg_q.rx_sel);
  assign rx_trig_nxt = sel_to_level(cfg_n.rx_sel);
  assign tx_trig_nxt = cfg_n.enh ? sel_to_level(cfg_n.tx_sel) : CW'(1);

endmodule

// File: rtl/fifo_trig_buf.sv
module fifo_trig_buf #(
  parameter int  DW    = 8,
  parameter int  DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_nxt,
  output logic          ovr
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          push_ok;
  logic          pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_ok    = en && pop && (level != '0);
    push_ok   = en && push && ((level != CW'(DEPTH)) || pop_ok);
    level_nxt = en ? (level + CW'(push_ok) - CW'(pop_ok)) : '0;
  end

  // Storage array: write port only, no reset, so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  // Registered read port (read-first on a shared address).
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (pop_ok) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovr    <= 1'b0;
    end else begin
      level <= level_nxt;
      if (!en) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        ovr    <= 1'b0;
      end else begin
        if (push_ok)          wr_ptr <= bump(wr_ptr);
        if (pop_ok)           rd_ptr <= bump(rd_ptr);
        if (push && !push_ok) ovr    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fifo_trig_tout.sv
module fifo_trig_tout #(
  parameter int  LIMIT = 64,
  localparam int TW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  input  logic cond,
  output logic fire
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || restart || !cond) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (cnt == TW'(LIMIT - 1)) begin
      fire <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq
  import fifo_trig_pkg::*;
#(
  parameter int  DW          = 8,
  parameter int  DEPTH       = 16,
  parameter int  CHAR_CYCLES = 16,
  parameter int  TOUT_CHARS  = 4,
  localparam int CW          = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_fifo_en,
  input  logic [1:0]    cfg_rx_sel,
  input  logic [1:0]    cfg_tx_sel,
  input  logic          cfg_enh,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic [CW-1:0] tx_level,
  output logic          tx_ovr,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  output logic [CW-1:0] rx_level,
  output logic          rx_ovr,
  output logic          irq_rx_data,
  output logic          irq_tx_empty,
  output logic          irq_rx_tout
);

  localparam int TOUT_LIMIT = TOUT_CHARS * CHAR_CYCLES;

  trig_cfg_t     cfg_in;
  logic          en_q;
  logic          en_nxt;
  logic [CW-1:0] rx_trig_q;
  logic [CW-1:0] rx_trig_nxt;
  logic [CW-1:0] tx_trig_nxt;
  logic [CW-1:0] rx_level_nxt;
  logic [CW-1:0] tx_level_nxt;
  logic          tout_cond;
  logic          tout_restart;

  always_comb begin
    cfg_in.en     = cfg_fifo_en;
    cfg_in.rx_sel = trig_sel_t'(cfg_rx_sel);
    cfg_in.tx_sel = trig_sel_t'(cfg_tx_sel);
    cfg_in.enh    = cfg_enh;
  end

  fifo_trig_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_in     (cfg_in),
    .en_q       (en_q),
    .en_nxt     (en_nxt),
    .rx_trig_q  (rx_trig_q),
    .rx_trig_nxt(rx_trig_nxt),
    .tx_trig_nxt(tx_trig_nxt)
  );

  fifo_trig_buf #(.DW(DW), .DEPTH(DEPTH)) tx_buf_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en_nxt),
    .push     (tx_push),
    .din      (tx_din),
    .pop      (tx_pop),
    .dout     (tx_dout),
    .level    (tx_level),
    .level_nxt(tx_level_nxt),
    .ovr      (tx_ovr)
  );

  fifo_trig_buf #(.DW(DW), .DEPTH(DEPTH)) rx_buf_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en_nxt),
    .push     (rx_push),
    .din      (rx_din),
    .pop      (rx_pop),
    .dout     (rx_dout),
    .level    (rx_level),
    .level_nxt(rx_level_nxt),
    .ovr      (rx_ovr)
  );

  always_comb begin
    tout_cond    = (rx_level != '0) && (rx_level < rx_trig_q);
    tout_restart = rx_push || rx_pop || cfg_we;
  end

  fifo_trig_tout #(.LIMIT(TOUT_LIMIT)) tout_i (
    .clk    (clk),
    .rst    (rst),
    .en     (en_q),
    .restart(tout_restart),
    .cond   (tout_cond),
    .fire   (irq_rx_tout)
  );

  // Level interrupts look ahead at next-state values so they change together with the levels.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx_data  <= 1'b0;
      irq_tx_empty <= 1'b0;
    end else begin
      irq_rx_data  <= en_nxt && (rx_level_nxt >= rx_trig_nxt);
      irq_tx_empty <= en_nxt && (tx_level_nxt < tx_trig_nxt);
    end
  end

endmodule

// File: rtl/fifo_trig_irq_chk.sv
module fifo_trig_irq_chk #(
  parameter int  DW    = 8,
  parameter int  DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [DW-1:0] rx_dout,
  input logic [CW-1:0] rx_level,
  input logic          rx_ovr,
  input logic [CW-1:0] tx_level,
  input logic          irq_rx_data,
  input logic          irq_tx_empty,
  input logic          irq_rx_tout
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_level <= CW'(DEPTH)) && (tx_level <= CW'(DEPTH)));

  assert_ovr_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovr) |-> ($past(rx_push) && !$past(rx_pop) && ($past(rx_level) == CW'(DEPTH))));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_push && (rx_level == '0)) |=> ($stable(rx_dout) && (rx_level == '0)));

  assert_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> ((rx_level == '0) && (tx_level == '0) && !irq_rx_data && !irq_tx_empty && !irq_rx_tout));

  assert_rx_irq_R6: assert property (@(posedge clk) disable iff (rst)
    irq_rx_data |-> (rx_level != '0));

  assert_tx_irq_R7: assert property (@(posedge clk) disable iff (rst)
    irq_tx_empty |-> (tx_level < CW'(DEPTH)));

  assert_tout_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_rx_tout |-> (rx_level != '0));

  assert_tout_excl_R9: assert property (@(posedge clk) disable iff (rst)
    irq_rx_tout |-> !irq_rx_data);

endmodule

bind fifo_trig_irq fifo_trig_irq_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fifo_en     (en_q),
  .rx_push     (rx_push),
  .rx_pop      (rx_pop),
  .rx_dout     (rx_dout),
  .rx_level    (rx_level),
  .rx_ovr      (rx_ovr),
  .tx_level    (tx_level),
  .irq_rx_data (irq_rx_data),
  .irq_tx_empty(irq_tx_empty),
  .irq_rx_tout (irq_rx_tout)
);

// File: tb/fifo_trig_irq_tb_top.sv
`timescale 1ns/1ps
module fifo_trig_irq_tb_top;

  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int CCYC  = 8;
  localparam int TCH   = 4;
  localparam int LIM   = CCYC * TCH;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0, cfg_fifo_en = 1'b0, cfg_enh = 1'b0;
  logic [1:0]    cfg_rx_sel = 2'd0, cfg_tx_sel = 2'd0;
  logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [DW-1:0] tx_din = '0, rx_din = '0;
  logic [DW-1:0] tx_dout, rx_dout;
  logic [CW-1:0] tx_level, rx_level;
  logic          tx_ovr, rx_ovr, irq_rx_data, irq_tx_empty, irq_rx_tout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fifo_trig_irq #(.DW(DW), .DEPTH(DEPTH), .CHAR_CYCLES(CCYC), .TOUT_CHARS(TCH)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
    .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel), .cfg_enh(cfg_enh),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_level(tx_level), .tx_ovr(tx_ovr),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_level(rx_level), .rx_ovr(rx_ovr),
    .irq_rx_data(irq_rx_data), .irq_tx_empty(irq_tx_empty), .irq_rx_tout(irq_rx_tout)
  );

  // Receive walk with trigger 4: {push, pop, expected level[4:0], expected irq}
  localparam logic [7:0] VEC [12] = '{
    8'b1_0_00001_0, 8'b1_0_00010_0, 8'b1_0_00011_0, 8'b1_0_00100_1,
    8'b1_0_00101_1, 8'b0_1_00100_1, 8'b0_1_00011_0, 8'b1_1_00011_0,
    8'b0_1_00010_0, 8'b0_1_00001_0, 8'b0_1_00000_0, 8'b0_1_00000_0
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rstep(input bit ps, input bit pp, input logic [DW-1:0] d);
    @(negedge clk);
    rx_push = ps; rx_pop = pp; rx_din = d;
    @(posedge clk); #1;
    rx_push = 1'b0; rx_pop = 1'b0;
  endtask

  task automatic tstep(input bit ps, input bit pp, input logic [DW-1:0] d);
    @(negedge clk);
    tx_push = ps; tx_pop = pp; tx_din = d;
    @(posedge clk); #1;
    tx_push = 1'b0; tx_pop = 1'b0;
  endtask

  task automatic cfg(input bit en, input logic [1:0] rs, input logic [1:0] ts, input bit enh);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fifo_en = en; cfg_rx_sel = rs; cfg_tx_sel = ts; cfg_enh = enh;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 irqs", {irq_rx_data, irq_tx_empty, irq_rx_tout}, 0);
    chk("R1 ovr", {rx_ovr, tx_ovr}, 0);

    // R6 table walk, receive trigger code 1 (4 characters)
    cfg(1'b1, 2'd1, 2'd0, 1'b0);
    for (int i = 0; i < 12; i++) begin
      rstep(VEC[i][7], VEC[i][6], DW'(8'h40 + i));
      chk($sformatf("R6 vec%0d level", i), rx_level, int'(VEC[i][5:1]));
      chk($sformatf("R6 vec%0d irq", i), irq_rx_data, int'(VEC[i][0]));
    end
    chk("R2 last popped byte", rx_dout, 8'h47);

    // R3 full FIFO: push+pop collision, then dropped push
    for (int i = 0; i < DEPTH; i++) rstep(1'b1, 1'b0, DW'(8'h10 + i));
    chk("R2 full level", rx_level, DEPTH);
    chk("R3 no ovr at full", rx_ovr, 0);
    rstep(1'b1, 1'b1, 8'hAA);
    chk("R3 collision level", rx_level, DEPTH);
    chk("R3 collision ovr", rx_ovr, 0);
    chk("R3 collision dout", rx_dout, 8'h10);
    rstep(1'b1, 1'b0, 8'hBB);
    chk("R3 overrun set", rx_ovr, 1);
    chk("R3 overrun level", rx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rstep(1'b0, 1'b1, 8'h00);
      chk($sformatf("R2 drain %0d", i), rx_dout, (i < DEPTH - 1) ? (8'h11 + i) : 8'hAA);
    end
    chk("R2 drained level", rx_level, 0);
    // R4 empty pop
    rstep(1'b0, 1'b1, 8'h00);
    chk("R4 empty pop dout", rx_dout, 8'hAA);
    chk("R4 empty pop level", rx_level, 0);
    chk("R3 ovr sticky", rx_ovr, 1);

    // R5 disable flushes and ignores pushes
    rstep(1'b1, 1'b0, 8'h01);
    tstep(1'b1, 1'b0, 8'h02);
    cfg(1'b0, 2'd1, 2'd0, 1'b0);
    chk("R5 flush levels", {rx_level, tx_level}, 0);
    chk("R5 ovr cleared", rx_ovr, 0);
    rstep(1'b1, 1'b0, 8'h03);
    chk("R5 push ignored", rx_level, 0);
    chk("R5 irqs off", {irq_rx_data, irq_tx_empty, irq_rx_tout}, 0);

    // R7 transmit trigger and enhanced mode
    cfg(1'b1, 2'd1, 2'd2, 1'b0);
    chk("R7 trig1 empty irq", irq_tx_empty, 1);
    tstep(1'b1, 1'b0, 8'hC0);
    chk("R7 trig1 level1 irq", irq_tx_empty, 0);
    cfg(1'b1, 2'd1, 2'd2, 1'b1);
    chk("R7 enh trig8 level1 irq", irq_tx_empty, 1);
    for (int i = 1; i < 7; i++) tstep(1'b1, 1'b0, DW'(8'hC0 + i));
    chk("R7 level7 irq", irq_tx_empty, 1);
    tstep(1'b1, 1'b0, 8'hC7);
    chk("R7 level8 irq", irq_tx_empty, 0);
    tstep(1'b0, 1'b1, 8'h00);
    chk("R7 pop level7 irq", irq_tx_empty, 1);
    chk("R2 tx order", tx_dout, 8'hC0);
    cfg(1'b1, 2'd1, 2'd2, 1'b0);
    chk("R7 enh off irq", irq_tx_empty, 0);

    // R6 trigger codes 3 (14) and 2 (8)
    cfg(1'b0, 2'd3, 2'd0, 1'b0);
    cfg(1'b1, 2'd3, 2'd0, 1'b0);
    for (int i = 0; i < 13; i++) rstep(1'b1, 1'b0, DW'(i));
    chk("R6 trig14 at13", irq_rx_data, 0);
    rstep(1'b1, 1'b0, 8'h0D);
    chk("R6 trig14 at14", irq_rx_data, 1);
    cfg(1'b0, 2'd2, 2'd0, 1'b0);
    cfg(1'b1, 2'd2, 2'd0, 1'b0);
    for (int i = 0; i < 7; i++) rstep(1'b1, 1'b0, DW'(i));
    chk("R6 trig8 at7", irq_rx_data, 0);
    rstep(1'b1, 1'b0, 8'h07);
    chk("R6 trig8 at8", irq_rx_data, 1);

    // R8 time-out with trigger 4
    cfg(1'b0, 2'd1, 2'd0, 1'b0);
    cfg(1'b1, 2'd1, 2'd0, 1'b0);
    rstep(1'b1, 1'b0, 8'h55);
    repeat (LIM - 1) @(posedge clk);
    #1 chk("R8 tout before window", irq_rx_tout, 0);
    @(posedge clk); #1;
    chk("R8 tout at window", irq_rx_tout, 1);
    chk("R8 data irq low", irq_rx_data, 0);
    rstep(1'b1, 1'b0, 8'h56);
    chk("R8 push clears tout", irq_rx_tout, 0);
    repeat (LIM - 4) @(posedge clk);
    rstep(1'b1, 1'b0, 8'h57);
    repeat (LIM - 1) @(posedge clk);
    #1 chk("R8 restart holds low", irq_rx_tout, 0);
    @(posedge clk); #1;
    chk("R8 restart fires", irq_rx_tout, 1);
    rstep(1'b0, 1'b1, 8'h00);
    chk("R8 pop clears tout", irq_rx_tout, 0);

    // R9 no time-out at or above trigger
    rstep(1'b1, 1'b0, 8'h58);
    rstep(1'b1, 1'b0, 8'h59);
    chk("R9 level", rx_level, 4);
    repeat (LIM + 4) @(posedge clk);
    #1 chk("R9 no tout", irq_rx_tout, 0);
    chk("R9 data irq", irq_rx_data, 1);

    finish_run();
  end

endmodule